// File: doc/BRIEF.md
# Status Packet Generator

The block turns a parallel status word of up to 26 bits into a short byte-serial packet and hands it to a downstream collector through a request/start handshake. While it has a packet ready, the block holds its request line high and presents a fixed address byte, which is a parameter. The collector accepts that byte by pulsing start. The payload bytes then follow on consecutive cycles, with no further handshake.

Software controls reporting through one 8-bit control write. The top two bits choose the reporting mode. The low six bits are a sequence number that the block echoes in every packet, so a reader can match each reply to the write that asked for it. In single-shot mode exactly one packet is sent. In automatic mode one packet is sent when the mode is entered, and another whenever the status differs from the value last sent. The status word and the sequence number are captured when start is accepted, so all bytes of a packet describe one instant.

Top module: `status_pkt_gen`

## Requirements
- R1: After reset the request output is low and the byte output is 0x00.
- R2: A control write with bits [7:6] = 01 (single-shot) raises the request from the next cycle, and the byte output then shows the address parameter.
- R3: The request stays high until start is seen together with it. A start pulse while the request is low is ignored, and the byte output stays 0x00.
- R4: The cycle after start is accepted, the byte output is {sequence[5:0], status[1:0]}. The following cycles show status[9:2], then status[17:10], then status[25:18].
- R5: The payload bytes come from the status value present in the cycle start was accepted. Later status changes do not alter them.
- R6: The request is low while payload bytes are sent. It may rise again in the cycle after the last payload byte.
- R7: A single-shot write yields exactly one packet. No request follows it unless a new write asks for one.
- R8: A control write with bits [7:6] = 11 (automatic) sends one packet at once. After that, a packet is requested only when the status input differs from the last value sent.
- R9: In automatic mode, any status change during a packet causes exactly one further packet after it ends, carrying the new value.
- R10: A control write with bits [7:6] = 00 or 10 cancels a pending single-shot request and stops automatic reporting.
- R11: The sequence number is bits [5:0] of the control write. A write during a packet does not change that packet, and the next packet carries the new number.
- R12: The packet has 1 + (ceil((PAYLOAD_W - 2) / 8) + 1) bytes. Status bits above PAYLOAD_W - 1 in the last byte are sent as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Control write strobe |
| ctl_data | input | 8 | Control byte: [7:6] mode, [5:0] sequence number |
| status_in | input | PAYLOAD_W | Parallel status word |
| pkt_req | output | 1 | Packet ready, waiting for start |
| pkt_start | input | 1 | Downstream accepts the address byte |
| pkt_byte | output | 8 | Packet byte stream |

## Verification
The assertions assume that the collector treats start as meaningful only while the request is high. The design ignores start at any other time. The assertions also assume that the status input may change in any cycle, including during a packet. The stimulus drives every input half a cycle away from the sampling edge and holds start for exactly one cycle. It also deliberately pulses start while no request is pending, and changes the status in the middle of a packet. A second instance with a 12-bit payload exercises the shorter packet and the zero padding in its last byte.

// File: rtl/spg_pkg.sv
package spg_pkg;

  // Reporting mode, taken from control byte bits [7:6]
  typedef enum logic [1:0] {
    RPT_OFF  = 2'd0,
    RPT_ONCE = 2'd1,
    RPT_RSVD = 2'd2,
    RPT_AUTO = 2'd3
  } rpt_mode_e;

  // Payload bytes: one byte carries the sequence and the two lowest status bits,
  // the rest carry the remaining status bits eight at a time.
  function automatic int payload_bytes(input int width);
    return (width - 2 + 7) / 8 + 1;
  endfunction

  // Total packet length, including the address byte
  function automatic int packet_bytes(input int width);
    return payload_bytes(width) + 1;
  endfunction

  // Width of the zero-extended status holding register
  function automatic int hold_width(input int width);
    return 2 + 8 * (payload_bytes(width) - 1);
  endfunction

endpackage

// File: rtl/spg_ctrl.sv
module spg_ctrl
  import spg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic [7:0] ctl_data,
  input  logic       accept,
  output logic       once_pend,
  output logic       auto_en,
  output logic [5:0] seq
);

  rpt_mode_e wr_mode;
  assign wr_mode = rpt_mode_e'(ctl_data[7:6]);

  always_ff @(posedge clk) begin
    if (rst) begin
      once_pend <= 1'b0;
      auto_en   <= 1'b0;
      seq       <= '0;
    end else begin
      if (accept) once_pend <= 1'b0;
      if (ctl_we) begin
        seq <= ctl_data[5:0];
        case (wr_mode)
          RPT_ONCE: begin once_pend <= 1'b1; auto_en <= 1'b0; end
          RPT_AUTO: begin once_pend <= 1'b1; auto_en <= 1'b1; end
          default:  begin once_pend <= 1'b0; auto_en <= 1'b0; end
        endcase
      end
    end
  end

  assert_off_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_data[6]) |=> (!once_pend && !auto_en));

  assert_once_consumed_R7: assert property (@(posedge clk) disable iff (rst)
    (accept && !ctl_we) |=> !once_pend);

endmodule

// File: rtl/spg_change.sv
module spg_change #(
  parameter int PAYLOAD_W = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic                 accept,
  output logic                 changed
);

  logic [PAYLOAD_W-1:0] last_sent;

  always_ff @(posedge clk) begin
    if (rst)         last_sent <= '0;
    else if (accept) last_sent <= status_in;
  end

  assign changed = (status_in != last_sent);

  // After a packet is taken, a difference can only come from a new input value
  assert_snapshot_R9: assert property (@(posedge clk) disable iff (rst)
    accept |=> (changed == (status_in != $past(status_in))));

endmodule

// File: rtl/spg_serial.sv
module spg_serial
  import spg_pkg::*;
#(
  parameter logic [7:0] REG_ADDR  = 8'h3C,
  parameter int         PAYLOAD_W = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 want,
  input  logic                 pkt_start,
  input  logic [PAYLOAD_W-1:0] status_in,
  input  logic [5:0]           seq,
  output logic                 accept,
  output logic                 busy,
  output logic                 pkt_req,
  output logic [7:0]           pkt_byte
);

  localparam int NPB  = payload_bytes(PAYLOAD_W);
  localparam int NB   = packet_bytes(PAYLOAD_W);
  localparam int HW   = hold_width(PAYLOAD_W);
  localparam int IDXW = $clog2(NB);
  localparam logic [IDXW-1:0] LAST = IDXW'(NB - 1);

  logic [IDXW-1:0] idx;
  logic [HW-1:0]   hold_ext;
  logic [HW-1:0]   status_ext;
  logic [5:0]      hold_seq;
  logic [7:0]      pb [NPB];

  assign busy    = (idx != '0);
  assign pkt_req = want && !busy;
  assign accept  = pkt_req && pkt_start;

  always_comb begin
    status_ext = '0;
    status_ext[PAYLOAD_W-1:0] = status_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      hold_ext <= '0;
      hold_seq <= '0;
    end else if (accept) begin
      idx      <= IDXW'(1);
      hold_ext <= status_ext;
      hold_seq <= seq;
    end else if (busy) begin
      idx <= (idx == LAST) ? '0 : idx + 1'b1;
    end
  end

  assign pb[0] = {hold_seq, hold_ext[1:0]};
  for (genvar k = 1; k < NPB; k++) begin : g_pbyte
    assign pb[k] = hold_ext[8*k-6 +: 8];
  end

  always_comb begin
    pkt_byte = 8'h00;
    if (busy) begin
      for (int k = 0; k < NPB; k++)
        if (int'(idx) == k + 1) pkt_byte = pb[k];
    end else if (pkt_req) begin
      pkt_byte = REG_ADDR;
    end
  end

  assert_req_low_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !pkt_req);

  assert_accept_starts_R3: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && !pkt_req));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hold_ext) && $stable(hold_seq));

  assert_last_ends_R12: assert property (@(posedge clk) disable iff (rst)
    (busy && idx == LAST) |=> !busy);

endmodule

// File: rtl/status_pkt_gen.sv
module status_pkt_gen
  import spg_pkg::*;
#(
  parameter logic [7:0] REG_ADDR  = 8'h3C,
  parameter int         PAYLOAD_W = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctl_we,
  input  logic [7:0]           ctl_data,
  input  logic [PAYLOAD_W-1:0] status_in,
  output logic                 pkt_req,
  input  logic                 pkt_start,
  output logic [7:0]           pkt_byte
);

  logic       accept;
  logic       busy;
  logic       once_pend;
  logic       auto_en;
  logic       changed;
  logic [5:0] seq;
  logic       want;

  assign want = once_pend || (auto_en && changed);

  spg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .accept(accept), .once_pend(once_pend), .auto_en(auto_en), .seq(seq)
  );

  spg_change #(.PAYLOAD_W(PAYLOAD_W)) u_change (
    .clk(clk), .rst(rst), .status_in(status_in), .accept(accept), .changed(changed)
  );

  spg_serial #(.REG_ADDR(REG_ADDR), .PAYLOAD_W(PAYLOAD_W)) u_serial (
    .clk(clk), .rst(rst), .want(want), .pkt_start(pkt_start),
    .status_in(status_in), .seq(seq), .accept(accept), .busy(busy),
    .pkt_req(pkt_req), .pkt_byte(pkt_byte)
  );

  // A packet is requested only when something asked for it
  assert_req_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
    pkt_req |-> (once_pend || auto_en));

endmodule

// File: tb/status_pkt_gen_test.sv
module status_pkt_gen_test;

  localparam logic [7:0] ADDR  = 8'h3C;
  localparam logic [7:0] ADDRN = 8'h3D;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_data = 8'h00;
  logic [25:0] status_in = '0;
  logic        pkt_start = 1'b0;
  logic        pkt_req;
  logic [7:0]  pkt_byte;

  logic        n_we = 1'b0;
  logic [7:0]  n_data = 8'h00;
  logic [11:0] n_status = '0;
  logic        n_start = 1'b0;
  logic        n_req;
  logic [7:0]  n_byte;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  status_pkt_gen #(.REG_ADDR(ADDR), .PAYLOAD_W(26)) uut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_data(ctl_data),
    .status_in(status_in), .pkt_req(pkt_req), .pkt_start(pkt_start),
    .pkt_byte(pkt_byte)
  );

  status_pkt_gen #(.REG_ADDR(ADDRN), .PAYLOAD_W(12)) uut_narrow (
    .clk(clk), .rst(rst), .ctl_we(n_we), .ctl_data(n_data),
    .status_in(n_status), .pkt_req(n_req), .pkt_start(n_start),
    .pkt_byte(n_byte)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Expected byte k (k = 1 is the first payload byte), by shifting
  function automatic logic [7:0] xb(input logic [31:0] st, input logic [5:0] sq, input int k);
    if (k == 1) return {sq, st[1:0]};
    return 8'((st >> 2) >> (8 * (k - 2)));
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    ctl_we = 1'b1; ctl_data = d;
    @(negedge clk);
    ctl_we = 1'b0;
    #1;
  endtask

  // Receive one 5-byte packet; optional mid-packet status change and control write
  task automatic recv(input logic [25:0] st, input logic [5:0] sq, input string tag,
                      input bit chg, input logic [25:0] st2, input bit wmid, input logic [7:0] wd);
    check(pkt_req === 1'b1, {tag, " R2 req"}, int'(pkt_req), 1);
    check(pkt_byte === ADDR, {tag, " R2 addr"}, int'(pkt_byte), int'(ADDR));
    pkt_start = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      pkt_start = 1'b0;
      if (chg && k == 1) status_in = st2;
      if (wmid && k == 2) begin ctl_we = 1'b1; ctl_data = wd; end
      if (wmid && k == 3) ctl_we = 1'b0;
      #1;
      check(pkt_byte === xb(32'(st), sq, k), {tag, " R4 byte"}, int'(pkt_byte), int'(xb(32'(st), sq, k)));
      check(pkt_req === 1'b0, {tag, " R6 req low"}, int'(pkt_req), 0);
    end
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    check(pkt_req === 1'b0, "R1 req", int'(pkt_req), 0);
    check(pkt_byte === 8'h00, "R1 byte", int'(pkt_byte), 0);
  endtask

  task automatic t_once;
    status_in = 26'h2A5_C3E1;
    @(negedge clk); pkt_start = 1'b1;
    @(negedge clk); pkt_start = 1'b0; #1;
    check(pkt_req === 1'b0, "R3 stray start req", int'(pkt_req), 0);
    check(pkt_byte === 8'h00, "R3 stray start byte", int'(pkt_byte), 0);
    wr({2'b01, 6'd5});
    cyc(3);
    check(pkt_req === 1'b1, "R3 req held", int'(pkt_req), 1);
    recv(26'h2A5_C3E1, 6'd5, "once", 1'b0, '0, 1'b0, 8'h00);
    check(pkt_req === 1'b0, "R7 single", int'(pkt_req), 0);
    cyc(4);
    check(pkt_req === 1'b0, "R7 still idle", int'(pkt_req), 0);
  endtask

  task automatic t_midchange;
    status_in = 26'h155_AA55;
    wr({2'b01, 6'd9});
    recv(26'h155_AA55, 6'd9, "R5 mid", 1'b1, 26'h0F0_F0F0, 1'b0, 8'h00);
    check(pkt_req === 1'b0, "R5 once no repeat", int'(pkt_req), 0);
  endtask

  task automatic t_auto;
    status_in = 26'h001_2345;
    wr({2'b11, 6'd33});
    recv(26'h001_2345, 6'd33, "R8 enter", 1'b0, '0, 1'b0, 8'h00);
    cyc(3);
    check(pkt_req === 1'b0, "R8 no change", int'(pkt_req), 0);
    @(negedge clk); status_in = 26'h3FF_0001; #1;
    check(pkt_req === 1'b1, "R8 change req", int'(pkt_req), 1);
    recv(26'h3FF_0001, 6'd33, "R8 change", 1'b0, '0, 1'b0, 8'h00);
    check(pkt_req === 1'b0, "R8 idle after", int'(pkt_req), 0);
  endtask

  task automatic t_auto_mid;
    status_in = 26'h222_2222;
    #1;
    check(pkt_req === 1'b1, "R9 change req", int'(pkt_req), 1);
    recv(26'h222_2222, 6'd33, "R9 first", 1'b1, 26'h111_1111, 1'b0, 8'h00);
    check(pkt_req === 1'b1, "R9 rerequest", int'(pkt_req), 1);
    recv(26'h111_1111, 6'd33, "R9 second", 1'b0, '0, 1'b0, 8'h00);
    check(pkt_req === 1'b0, "R9 exactly one more", int'(pkt_req), 0);
  endtask

  task automatic t_off;
    wr({2'b00, 6'd1});
    @(negedge clk); status_in = 26'h0AB_CDEF; #1;
    check(pkt_req === 1'b0, "R10 auto stopped", int'(pkt_req), 0);
    wr({2'b01, 6'd2});
    wr({2'b10, 6'd3});
    check(pkt_req === 1'b0, "R10 reserved cancels", int'(pkt_req), 0);
    check(pkt_byte === 8'h00, "R10 byte idle", int'(pkt_byte), 0);
  endtask

  task automatic t_seq;
    status_in = 26'h300_0003;
    wr({2'b01, 6'd7});
    recv(26'h300_0003, 6'd7, "R11 old seq", 1'b0, '0, 1'b1, {2'b01, 6'd42});
    check(pkt_req === 1'b1, "R11 next req", int'(pkt_req), 1);
    recv(26'h300_0003, 6'd42, "R11 new seq", 1'b0, '0, 1'b0, 8'h00);
  endtask

  task automatic t_narrow;
    logic [7:0] exp [4];
    n_status = 12'hABC;
    @(negedge clk); n_we = 1'b1; n_data = {2'b01, 6'd17};
    @(negedge clk); n_we = 1'b0; #1;
    exp[0] = ADDRN;
    for (int k = 1; k < 4; k++) exp[k] = xb(32'h0000_0ABC, 6'd17, k);
    check(n_req === 1'b1, "R12 narrow req", int'(n_req), 1);
    check(n_byte === exp[0], "R12 narrow addr", int'(n_byte), int'(exp[0]));
    n_start = 1'b1;
    for (int k = 1; k < 4; k++) begin
      @(negedge clk); n_start = 1'b0; #1;
      check(n_byte === exp[k], "R12 narrow byte", int'(n_byte), int'(exp[k]));
    end
    @(negedge clk); #1;
    check(n_req === 1'b0 && n_byte === 8'h00, "R12 narrow length", int'(n_byte), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_once();
    t_midchange();
    t_auto();
    t_auto_mid();
    t_off();
    t_seq();
    t_narrow();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule